// File: doc/BRIEF.md
# Sector Hamming Syndrome Classifier

This block checks one 512-byte sector after a flash read. It takes two 3-byte Hamming codes in the same cycle. One code is the copy kept in the spare area. The other is the code just computed over the data that was read. Both codes are unpacked into an aligned 28-bit word, and the two words are XORed into a syndrome. The block counts the set bits of the syndrome and decides among four outcomes: the sector is clean, one data bit is wrong and can be repaired, the stored code itself took a hit, or the damage cannot be repaired.

When one data bit is wrong, the block reports which byte of the sector holds it and which bit of that byte to invert. Repairing the buffer is left to the caller. The result is registered. It appears one clock after the input strobe, together with a one-cycle completion pulse, and stays on the outputs until the next strobe.

Each 3-byte code is presented as a 24-bit port. Code byte 0 sits in bits 7:0, code byte 1 in bits 15:8, and code byte 2 in bits 23:16.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: While reset is high and after its release, `out_done` is 0, `out_status` is 0 and both index outputs are 0 until the first strobe.
- R2: A strobe on `in_valid` gives exactly one `out_done` pulse, on the clock after the strobe, and the results appear with it. A cycle without a strobe gives no pulse.
- R3: Each code is unpacked as follows: byte 0 goes to word bits 7:0, the low nibble of byte 2 to bits 11:8, byte 1 to bits 23:16, and the high nibble of byte 2 to bits 27:24. When the two codes are equal, the status is 0 (clean).
- R4: When the syndrome has exactly 12 set bits, the status is 1 (fixable). The bit index is the syndrome XOR of code bits 10:8. The byte index, 0 to 511, is the XOR of code bits 23:20 as its upper four bits and of code bits 15:11 as its lower five bits.
- R5: When the syndrome has exactly one set bit, the status is 2 (the stored code is corrupt).
- R6: Any other nonzero syndrome gives status 3 (uncorrectable).
- R7: Whenever the status is not 1, the byte index and the bit index are 0.
- R8: Input values in cycles without a strobe have no effect. All outputs keep their last values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: both codes are valid this cycle |
| stored_code | input | 24 | Code read back from the spare area |
| calc_code | input | 24 | Code computed from the read data |
| out_done | output | 1 | One-cycle pulse: result is valid |
| out_status | output | 2 | 0 clean, 1 fixable, 2 code corrupt, 3 uncorrectable |
| out_byte_idx | output | 9 | Byte to repair (0 when the status is not 1) |
| out_bit_idx | output | 3 | Bit to repair (0 when the status is not 1) |

## Verification
The bench walks all 4096 single-data-bit error locations. Each one is built as a 12-bit location in the upper half of the syndrome with its complement in the lower half. A design that took the location from the wrong half, or that swapped the nibbles of byte 2, would report the wrong byte or bit index.

All 24 single-bit code flips must report a corrupt code, and every two-bit pair must report uncorrectable. A classifier that tested the count of 1 after the general nonzero case, or that treated a weight of 2 as fixable, would fail these sweeps.

After every strobe the bench drives fresh junk on the inputs with the strobe low. This catches a design whose registers follow the inputs without a strobe, or whose done signal stretches beyond one cycle.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int SECTOR_BYTES = 512;
  localparam int CODE_BYTES   = 3;
  localparam int CODE_W       = CODE_BYTES * 8;
  localparam int ALIGN_W      = 28;
  localparam int PARITY_PAIRS = 12;
  localparam int BIT_IDX_W    = 3;
  localparam int BYTE_IDX_W   = $clog2(SECTOR_BYTES);
  localparam int LOC_LSB      = 16;
  localparam int CNT_W        = $clog2(ALIGN_W + 1);

  typedef enum logic [1:0] {
    ST_CLEAN      = 2'd0,
    ST_FIXABLE    = 2'd1,
    ST_CODE_FAULT = 2'd2,
    ST_UNFIXABLE  = 2'd3
  } fix_status_e;
endpackage

// File: rtl/ecc_code_unpack.sv
// Moves the three code bytes into the aligned word. Byte 2 is split into two nibbles.
module ecc_code_unpack
  import ecc_fix_pkg::*;
(
  input  logic [CODE_W-1:0]  raw,
  output logic [ALIGN_W-1:0] aligned
);
  always_comb begin
    aligned        = '0;
    aligned[7:0]   = raw[7:0];
    aligned[11:8]  = raw[19:16];
    aligned[23:16] = raw[15:8];
    aligned[27:24] = raw[23:20];
  end
endmodule

// File: rtl/ecc_popcount.sv
// Counts the set bits of a vector.
module ecc_popcount #(
  parameter int W     = 28,
  parameter int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + OUT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/ecc_classify.sv
// Sorts the syndrome into one of the four outcomes and pulls out the location to repair.
module ecc_classify
  import ecc_fix_pkg::*;
#(
  parameter int PAIRS = PARITY_PAIRS
) (
  input  logic [ALIGN_W-1:0]    syndrome,
  input  logic [CNT_W-1:0]      weight,
  output fix_status_e           status,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx
);
  localparam int LOC_W = BYTE_IDX_W + BIT_IDX_W;

  logic [LOC_W-1:0] loc;
  assign loc = syndrome[LOC_LSB +: LOC_W];

  always_comb begin
    byte_idx = '0;
    bit_idx  = '0;
    if (syndrome == '0) begin
      status = ST_CLEAN;
    end else if (weight == CNT_W'(PAIRS)) begin
      status   = ST_FIXABLE;
      bit_idx  = loc[BIT_IDX_W-1:0];
      byte_idx = loc[LOC_W-1:BIT_IDX_W];
    end else if (weight == CNT_W'(1)) begin
      status = ST_CODE_FAULT;
    end else begin
      status = ST_UNFIXABLE;
    end
  end
endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
  import ecc_fix_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int BYW   = BYTE_IDX_W,
  parameter int BIW   = BIT_IDX_W,
  parameter int PAIRS = PARITY_PAIRS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [CW-1:0]  stored_code,
  input  logic [CW-1:0]  calc_code,
  output logic           out_done,
  output logic [1:0]     out_status,
  output logic [BYW-1:0] out_byte_idx,
  output logic [BIW-1:0] out_bit_idx
);
  localparam int NCODES = 2;

  logic [NCODES-1:0][CW-1:0]      raw_codes;
  logic [NCODES-1:0][ALIGN_W-1:0] al_codes;
  logic [ALIGN_W-1:0]             syndrome;
  logic [CNT_W-1:0]               weight;
  fix_status_e                    st_d, st_q;
  logic [BYW-1:0]                 byte_d, byte_q;
  logic [BIW-1:0]                 bit_d, bit_q;
  logic                           done_q;

  assign raw_codes[0] = stored_code;
  assign raw_codes[1] = calc_code;

  for (genvar g = 0; g < NCODES; g++) begin : g_unpack
    ecc_code_unpack u_unpack (
      .raw     (raw_codes[g]),
      .aligned (al_codes[g])
    );
  end

  assign syndrome = al_codes[0] ^ al_codes[1];

  ecc_popcount #(.W(ALIGN_W), .OUT_W(CNT_W)) u_pop (
    .vec   (syndrome),
    .count (weight)
  );

  ecc_classify #(.PAIRS(PAIRS)) u_cls (
    .syndrome (syndrome),
    .weight   (weight),
    .status   (st_d),
    .byte_idx (byte_d),
    .bit_idx  (bit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      st_q   <= ST_CLEAN;
      byte_q <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= in_valid;
      if (in_valid) begin
        st_q   <= st_d;
        byte_q <= byte_d;
        bit_q  <= bit_d;
      end
    end
  end

  assign out_done     = done_q;
  assign out_status   = st_q;
  assign out_byte_idx = byte_q;
  assign out_bit_idx  = bit_q;
endmodule

// File: rtl/ecc_fix_checker.sv
module ecc_fix_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [23:0] stored_code,
  input logic [23:0] calc_code,
  input logic        out_done,
  input logic [1:0]  out_status,
  input logic [8:0]  out_byte_idx,
  input logic [2:0]  out_bit_idx
);
  p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done);
  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_done);
  p_equal_is_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && stored_code == calc_code) |=> out_status == 2'd0);
  p_twelve_is_fixable_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(stored_code ^ calc_code) == 12) |=> out_status == 2'd1);
  p_one_is_code_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(stored_code ^ calc_code) == 1) |=> out_status == 2'd2);
  p_two_is_unfixable_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(stored_code ^ calc_code) == 2) |=> out_status == 2'd3);
  p_idx_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_status != 2'd1) |-> (out_byte_idx == 9'd0 && out_bit_idx == 3'd0));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_status) && $stable(out_byte_idx) && $stable(out_bit_idx)));
endmodule

bind ecc_syndrome_fixer ecc_fix_checker u_fix_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .stored_code  (stored_code),
  .calc_code    (calc_code),
  .out_done     (out_done),
  .out_status   (out_status),
  .out_byte_idx (out_byte_idx),
  .out_bit_idx  (out_bit_idx)
);

// File: tb/test_ecc_syndrome_fixer.sv
`timescale 1ns/1ps
module test_ecc_syndrome_fixer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        out_done;
  logic [1:0]  out_status;
  logic [8:0]  out_byte_idx;
  logic [2:0]  out_bit_idx;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  ecc_syndrome_fixer i_ecc_syndrome_fixer (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .stored_code(stored_code), .calc_code(calc_code),
    .out_done(out_done), .out_status(out_status),
    .out_byte_idx(out_byte_idx), .out_bit_idx(out_bit_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int weight24(input logic [23:0] v);
    int n = 0;
    for (int i = 0; i < 24; i++) n += int'(v[i]);
    return n;
  endfunction

  // Strobe one pair of codes, check the result, then drive junk without a strobe.
  // A loc_ref of -1 means: use only the arithmetic expectation.
  task automatic run(input logic [23:0] s, input logic [23:0] c, input int loc_ref);
    logic [23:0] d;
    int w, e_st, e_byte, e_bit;
    d = s ^ c;
    w = weight24(d);
    if (w == 0)       e_st = 0;
    else if (w == 12) e_st = 1;
    else if (w == 1)  e_st = 2;
    else              e_st = 3;
    e_byte = (e_st == 1) ? int'({d[23:20], d[15:11]}) : 0;
    e_bit  = (e_st == 1) ? int'(d[10:8]) : 0;
    @(negedge clk);
    stored_code = s; calc_code = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    stored_code = 24'($urandom); calc_code = 24'($urandom);
    check(out_done == 1'b1, "R2 done pulse", int'(out_done), 1);
    case (e_st)
      0: check(out_status == 2'd0, "R3 clean status", int'(out_status), 0);
      1: check(out_status == 2'd1, "R4 fixable status", int'(out_status), 1);
      2: check(out_status == 2'd2, "R5 code fault status", int'(out_status), 2);
      default: check(out_status == 2'd3, "R6 unfixable status", int'(out_status), 3);
    endcase
    if (e_st == 1) begin
      check(int'(out_byte_idx) == e_byte, "R4 byte index", int'(out_byte_idx), e_byte);
      check(int'(out_bit_idx) == e_bit, "R4 bit index", int'(out_bit_idx), e_bit);
      if (loc_ref >= 0)
        check(int'({out_byte_idx, out_bit_idx}) == loc_ref, "R4 location",
              int'({out_byte_idx, out_bit_idx}), loc_ref);
    end else begin
      check(out_byte_idx == 9'd0 && out_bit_idx == 3'd0, "R7 index zero",
            int'({out_byte_idx, out_bit_idx}), 0);
    end
    @(negedge clk);
    check(out_done == 1'b0, "R2 single pulse", int'(out_done), 0);
    check(int'(out_status) == e_st, "R8 status hold", int'(out_status), e_st);
    check(int'(out_byte_idx) == e_byte && int'(out_bit_idx) == e_bit, "R8 index hold",
          int'({out_byte_idx, out_bit_idx}), (e_byte << 3) | e_bit);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
    $finish;
  end

  initial begin : stim
    logic [23:0] base;
    logic [11:0] hi, lo;
    repeat (3) @(negedge clk);
    check(out_done == 1'b0, "R1 reset done", int'(out_done), 0);
    check(out_status == 2'd0, "R1 reset status", int'(out_status), 0);
    check(out_byte_idx == 9'd0 && out_bit_idx == 3'd0, "R1 reset index",
          int'({out_byte_idx, out_bit_idx}), 0);
    rst = 1'b0;
    stored_code = 24'hABCDEF; calc_code = 24'h123456;
    @(negedge clk);
    @(negedge clk);
    check(out_done == 1'b0 && out_status == 2'd0, "R1 idle after reset",
          int'(out_status), 0);

    // R3: identical codes
    for (int k = 0; k < 8; k++) begin
      base = 24'($urandom);
      run(base, base, -1);
    end
    // R4: every single-data-bit location, complement in the lower half
    for (int loc = 0; loc < 4096; loc++) begin
      hi = 12'(loc);
      lo = ~hi;
      base = 24'($urandom);
      run(base, base ^ {hi[11:8], lo[11:8], hi[7:0], lo[7:0]}, loc);
    end
    // R4: weight 12 that is not of the Hamming shape
    run(24'h000000, 24'h000FFF, -1);
    run(24'hFFF000, 24'h000000, -1);
    // R5: every single code bit flip
    for (int i = 0; i < 24; i++) begin
      base = 24'($urandom);
      run(base, base ^ (24'd1 << i), -1);
    end
    // R6: every two-bit pair
    for (int i = 0; i < 24; i++)
      for (int j = i + 1; j < 24; j++) begin
        base = 24'($urandom);
        run(base, base ^ (24'd1 << i) ^ (24'd1 << j), -1);
      end
    // R6: weights 11, 13, 24
    run(24'h000000, 24'h0007FF, -1);
    run(24'h000000, 24'h001FFF, -1);
    run(24'h000000, 24'hFFFFFF, -1);
    // Mixed random pairs
    for (int k = 0; k < 200; k++) run(24'($urandom), 24'($urandom), -1);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule